// File: doc/BRIEF.md
# Stereo Audio FIFO Register Frontend

This block sits between a processor's register bus and a stereo audio processing core. Software writes a packed 32-bit word that carries one left and one right 16-bit sample. The block splits that word and pushes each half into its own channel FIFO. A control bit can exchange the two halves before they are stored. The core takes samples from each channel through its own valid/ready stream and returns 32-bit result words through a third stream. Those words collect in an output FIFO, and software drains it by reading a data register.

Software sees a control register, fill counts, programmable level thresholds, live FIFO flags, an interrupt enable register and a sticky interrupt status register. The status register is cleared by writing 1s, and one interrupt line reports the OR of its bits. Each FIFO has its own self-clearing reset bit. The transfer handshakes that a DMA engine would use are reduced to two request outputs. The register port is single-cycle: a write takes effect at the clock edge where `reg_wr` is high. Read data is registered, so it appears the cycle after `reg_rd`.

Back-pressure rules for the streams are as follows. A sample stream shows valid only while the block is enabled and its FIFO holds data, and a sample leaves on any cycle where valid and ready are both high. The result stream shows ready only while the block is enabled and the output FIFO is not full. A word offered while ready is low is not taken, and the core must hold it.

Top module: `stereo_fifo_front`

## Requirements
- R1: After reset the fill counts are zero, the state register at 0x18 reads 0x662, `irq` is low and both sample streams show valid low.
- R2: A write to offset 0x08 pushes bits 15:0 to the left FIFO and bits 31:16 to the right FIFO at the same edge. Each count rises by one.
- R3: When control bit 1 (swap) is set, bits 31:16 of an input write go to the left FIFO and bits 15:0 go to the right FIFO.
- R4: `l_valid`/`r_valid` are high only when control bit 0 (run) is set and the FIFO is not empty. The data shown is the oldest sample, and one sample is removed per valid-and-ready cycle.
- R5: `res_ready` is high when run is set and the output FIFO is not full. Each accepted word is stored in order. A read of offset 0x0C returns and removes the oldest word. On an empty FIFO that read returns 0 and leaves the count at 0.
- R6: An input write to a full channel FIFO is dropped for that channel only. The other channel still accepts its half, and the full FIFO's contents and count stay unchanged.
- R7: A register push and a core pop on the same input FIFO in the same cycle leave its count unchanged, and the pushed sample is kept.
- R8: Offset 0x1C reads the left count in bits 8:0 and the right count in bits 24:16. Offset 0x20 reads the output count in bits 7:0.
- R9: Offset 0x24 holds the left almost-empty threshold in bits 7:0 and the right one in bits 23:16. Offset 0x28 holds the output almost-full threshold in bits 7:0, and its reset value is 64. Almost-empty means count <= threshold, and almost-full means count >= threshold. Offset 0x18 reports the flags as follows: output full/empty/almost-full in bits 0/1/2, left full/empty/almost-empty in bits 4/5/6, and right full/empty/almost-empty in bits 8/9/10.
- R10: Offset 0x10 enables interrupts using the same bit layout as 0x18. A status bit at 0x14 is set on any cycle where its flag and its enable are both high, and it stays set until a 1 is written to it. A live enabled condition wins over a clear in the same cycle. `irq` is the OR of all status bits.
- R11: Writing 1 to control bit 5, 6 or 7 empties the output, left or right FIFO respectively at the following edge, and leaves the other FIFOs untouched. Writing 1 to bit 4 raises `core_restart` for exactly one cycle. These four bits always read back as 0.
- R12: `in_dma_req` is control bit 8 AND (either input almost-empty) AND neither input full. `out_dma_req` is control bit 9 AND output almost-full AND output not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| l_valid | output | 1 | Left sample available |
| l_ready | input | 1 | Core takes the left sample |
| l_data | output | 16 | Oldest left sample |
| r_valid | output | 1 | Right sample available |
| r_ready | input | 1 | Core takes the right sample |
| r_data | output | 16 | Oldest right sample |
| res_valid | input | 1 | Core offers a result word |
| res_ready | output | 1 | Output FIFO accepts the word |
| res_data | input | 32 | Result word |
| irq | output | 1 | OR of the interrupt status bits |
| in_dma_req | output | 1 | Input refill request |
| out_dma_req | output | 1 | Output drain request |
| core_restart | output | 1 | One-cycle restart pulse to the core |

## Verification
A register push and a core pop can land on the same left FIFO in one cycle. The bench provokes this by raising `reg_wr` to offset 0x08 together with `l_ready` while one sample is stored. It then checks that the left count at 0x1C is unchanged, that the right count has risen, and that the new sample is at the head. A software clear of a status bit can also collide with a live enabled condition. This is judged by writing 1 to the output-empty status bit while the output FIFO is empty and its enable is set, and then expecting the bit to read back as still set.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // register byte offsets
  localparam logic [5:0] A_CTRL   = 6'h00;
  localparam logic [5:0] A_PUSH   = 6'h08;
  localparam logic [5:0] A_POP    = 6'h0C;
  localparam logic [5:0] A_IEN    = 6'h10;
  localparam logic [5:0] A_IST    = 6'h14;
  localparam logic [5:0] A_STATE  = 6'h18;
  localparam logic [5:0] A_INCNT  = 6'h1C;
  localparam logic [5:0] A_OUTCNT = 6'h20;
  localparam logic [5:0] A_INTHR  = 6'h24;
  localparam logic [5:0] A_OUTTHR = 6'h28;

  // control bit positions
  localparam int C_RUN      = 0;
  localparam int C_SWAP     = 1;
  localparam int C_CORE_RST = 4;
  localparam int C_OUT_CLR  = 5;
  localparam int C_L_CLR    = 6;
  localparam int C_R_CLR    = 7;
  localparam int C_IN_DMA   = 8;
  localparam int C_OUT_DMA  = 9;

  // event vector width and implemented bits
  localparam int          EV_W    = 11;
  localparam logic [10:0] EV_MASK = 11'h777;

  typedef struct packed {
    logic lvl;
    logic empty;
    logic full;
  } fifo_flags_t;
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo
  import sfe_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 256,
  parameter int THR_W    = 8,
  parameter bit LVL_HIGH = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  input  logic [THR_W-1:0]             thr,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output fifo_flags_t                  flags
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = (CW > THR_W) ? CW : THR_W;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  assign flags.full  = (cnt == CW'(DEPTH));
  assign flags.empty = (cnt == '0);
  assign do_push     = push && !flags.full && !clr;
  assign do_pop      = pop && !flags.empty && !clr;
  assign rdata       = mem[rp];
  assign count       = cnt;

  generate
    if (LVL_HIGH) begin : g_alfull
      assign flags.lvl = (XW'(cnt) >= XW'(thr));
    end else begin : g_alempty
      assign flags.lvl = (XW'(cnt) <= XW'(thr));
    end
  endgenerate

  always_comb begin
    case ({do_push, do_pop})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + PW'(1);
      cnt <= cnt_nxt;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && flags.full && !pop && !clr |=> cnt == $past(cnt));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && flags.empty && !push && !clr |=> cnt == '0);
  // R7
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !flags.full && !flags.empty && !clr |=> cnt == $past(cnt));
  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/sfe_irq.sv
module sfe_irq #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;
  assign irq     = |sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_eff) | (cond & en);
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R10
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[i]) |-> $past(cond[i] && en[i]));
      // R10
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts[i] && !(clr_wr && clr_bits[i]) |=> sts[i]);
    end
  endgenerate
endmodule

// File: rtl/stereo_fifo_front.sv
module stereo_fifo_front
  import sfe_pkg::*;
#(
  parameter int IN_DEPTH    = 256,
  parameter int OUT_DEPTH   = 128,
  parameter int SMP_W       = 16,
  parameter int THR_W       = 8,
  parameter int OUT_THR_RST = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [5:0]         reg_addr,
  input  logic [2*SMP_W-1:0] reg_wdata,
  output logic [2*SMP_W-1:0] reg_rdata,
  output logic               l_valid,
  input  logic               l_ready,
  output logic [SMP_W-1:0]   l_data,
  output logic               r_valid,
  input  logic               r_ready,
  output logic [SMP_W-1:0]   r_data,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic [2*SMP_W-1:0] res_data,
  output logic               irq,
  output logic               in_dma_req,
  output logic               out_dma_req,
  output logic               core_restart
);
  localparam int BUS_W = 2 * SMP_W;
  localparam int ICW   = $clog2(IN_DEPTH + 1);
  localparam int OCW   = $clog2(OUT_DEPTH + 1);

  // control state
  logic             run, swap, in_dma, out_dma;
  logic [3:0]       pulse_q;   // {r_clr, l_clr, out_clr, core}
  logic [THR_W-1:0] l_thr, r_thr, o_thr;
  logic [EV_W-1:0]  ien, sts, ev;

  // fifo side
  fifo_flags_t      l_fl, r_fl, o_fl;
  logic [ICW-1:0]   l_cnt, r_cnt;
  logic [OCW-1:0]   o_cnt;
  logic [BUS_W-1:0] o_head, rd_mux;
  logic [SMP_W-1:0] l_in, r_in;

  logic wr_ctrl, wr_push, wr_ist, rd_pop;
  logic l_pop, r_pop, o_push;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_push = reg_wr && (reg_addr == A_PUSH);
  assign wr_ist  = reg_wr && (reg_addr == A_IST);
  assign rd_pop  = reg_rd && (reg_addr == A_POP);

  assign l_in = swap ? reg_wdata[BUS_W-1:SMP_W] : reg_wdata[SMP_W-1:0];
  assign r_in = swap ? reg_wdata[SMP_W-1:0]     : reg_wdata[BUS_W-1:SMP_W];

  assign l_valid   = run && !l_fl.empty;
  assign r_valid   = run && !r_fl.empty;
  assign l_pop     = l_valid && l_ready;
  assign r_pop     = r_valid && r_ready;
  assign res_ready = run && !o_fl.full;
  assign o_push    = res_valid && res_ready;

  assign core_restart = pulse_q[0];

  // control and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      swap    <= 1'b0;
      in_dma  <= 1'b0;
      out_dma <= 1'b0;
      pulse_q <= '0;
      l_thr   <= '0;
      r_thr   <= '0;
      o_thr   <= THR_W'(OUT_THR_RST);
      ien     <= '0;
    end else begin
      pulse_q <= '0;
      if (wr_ctrl) begin
        run     <= reg_wdata[C_RUN];
        swap    <= reg_wdata[C_SWAP];
        in_dma  <= reg_wdata[C_IN_DMA];
        out_dma <= reg_wdata[C_OUT_DMA];
        pulse_q <= {reg_wdata[C_R_CLR], reg_wdata[C_L_CLR],
                    reg_wdata[C_OUT_CLR], reg_wdata[C_CORE_RST]};
      end
      if (reg_wr && reg_addr == A_INTHR) begin
        l_thr <= reg_wdata[THR_W-1:0];
        r_thr <= reg_wdata[16 +: THR_W];
      end
      if (reg_wr && reg_addr == A_OUTTHR) o_thr <= reg_wdata[THR_W-1:0];
      if (reg_wr && reg_addr == A_IEN)    ien   <= reg_wdata[EV_W-1:0] & EV_MASK;
    end
  end

  sfe_fifo #(.W(SMP_W), .DEPTH(IN_DEPTH), .THR_W(THR_W), .LVL_HIGH(1'b0)) u_left (
    .clk(clk), .rst_n(rst_n), .clr(pulse_q[2]), .push(wr_push), .wdata(l_in),
    .pop(l_pop), .rdata(l_data), .thr(l_thr), .count(l_cnt), .flags(l_fl)
  );

  sfe_fifo #(.W(SMP_W), .DEPTH(IN_DEPTH), .THR_W(THR_W), .LVL_HIGH(1'b0)) u_right (
    .clk(clk), .rst_n(rst_n), .clr(pulse_q[3]), .push(wr_push), .wdata(r_in),
    .pop(r_pop), .rdata(r_data), .thr(r_thr), .count(r_cnt), .flags(r_fl)
  );

  sfe_fifo #(.W(BUS_W), .DEPTH(OUT_DEPTH), .THR_W(THR_W), .LVL_HIGH(1'b1)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(pulse_q[1]), .push(o_push), .wdata(res_data),
    .pop(rd_pop), .rdata(o_head), .thr(o_thr), .count(o_cnt), .flags(o_fl)
  );

  // live event vector, same layout as the state register
  assign ev = {r_fl.lvl, r_fl.empty, r_fl.full, 1'b0,
               l_fl.lvl, l_fl.empty, l_fl.full, 1'b0,
               o_fl.lvl, o_fl.empty, o_fl.full};

  sfe_irq #(.N(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .cond(ev), .en(ien),
    .clr_wr(wr_ist), .clr_bits(reg_wdata[EV_W-1:0]), .sts(sts), .irq(irq)
  );

  assign in_dma_req  = in_dma && (l_fl.lvl || r_fl.lvl) && !l_fl.full && !r_fl.full;
  assign out_dma_req = out_dma && o_fl.lvl && !o_fl.empty;

  // read mux
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[C_RUN]     = run;
        rd_mux[C_SWAP]    = swap;
        rd_mux[C_IN_DMA]  = in_dma;
        rd_mux[C_OUT_DMA] = out_dma;
      end
      A_POP:    rd_mux = o_fl.empty ? '0 : o_head;
      A_IEN:    rd_mux[EV_W-1:0] = ien;
      A_IST:    rd_mux[EV_W-1:0] = sts;
      A_STATE:  rd_mux[EV_W-1:0] = ev;
      A_INCNT: begin
        rd_mux[15:0]  = 16'(l_cnt);
        rd_mux[31:16] = 16'(r_cnt);
      end
      A_OUTCNT: rd_mux[15:0] = 16'(o_cnt);
      A_INTHR: begin
        rd_mux[THR_W-1:0]  = l_thr;
        rd_mux[16 +: THR_W] = r_thr;
      end
      A_OUTTHR: rd_mux[THR_W-1:0] = o_thr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && o_fl.empty |=> reg_rdata == '0);
  // R11
  core_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_restart && !(wr_ctrl && reg_wdata[C_CORE_RST]) |=> !core_restart);
  // R4
  stream_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid || r_valid || res_ready) |-> run);
endmodule

// File: tb/sim_stereo_fifo_front.sv
module sim_stereo_fifo_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        l_valid, r_valid, res_ready;
  logic        l_ready = 1'b0, r_ready = 1'b0, res_valid = 1'b0;
  logic [15:0] l_data, r_data;
  logic [31:0] res_data = '0;
  logic        irq, in_dma_req, out_dma_req, core_restart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stereo_fifo_front u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .l_valid(l_valid), .l_ready(l_ready), .l_data(l_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .irq(irq), .in_dma_req(in_dma_req), .out_dma_req(out_dma_req),
    .core_restart(core_restart)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pop_lr(input bit pl, input bit pr);
    @(negedge clk); l_ready = pl; r_ready = pr;
    @(negedge clk); l_ready = 1'b0; r_ready = 1'b0;
  endtask

  task automatic push_res(input logic [31:0] d);
    @(negedge clk); res_valid = 1'b1; res_data = d;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h18, v); chk("R1 state", v, 32'h662);
    rd(6'h1C, v); chk("R1 in counts", v, 0);
    rd(6'h20, v); chk("R1 out count", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 valids", {30'd0, l_valid, r_valid}, 0);
  endtask

  task automatic t_split;
    logic [31:0] v;
    wr(6'h00, 32'h1);
    wr(6'h08, 32'hBEEF_1234);
    rd(6'h1C, v); chk("R2 counts", v, 32'h0001_0001);
    chk("R8 left field", 32'(v[8:0]), 1);
    chk("R2 left data", 32'(l_data), 32'h1234);
    chk("R2 right data", 32'(r_data), 32'hBEEF);
    chk("R4 valid when run", {30'd0, l_valid, r_valid}, 3);
  endtask

  task automatic t_swap;
    wr(6'h00, 32'h3);
    wr(6'h08, 32'hAAAA_5555);
    pop_lr(1'b1, 1'b1);
    chk("R3 left swapped", 32'(l_data), 32'hAAAA);
    chk("R3 right swapped", 32'(r_data), 32'h5555);
    wr(6'h00, 32'h1);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(6'h00, 32'h0);
    chk("R4 valid gated", {29'd0, l_valid, r_valid, res_ready}, 0);
    pop_lr(1'b1, 1'b1);
    rd(6'h1C, v); chk("R4 no pop while stopped", v, 32'h0001_0001);
    wr(6'h00, 32'h1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    @(negedge clk);
    reg_addr = 6'h08; reg_wdata = 32'h7777_6666; reg_wr = 1'b1; l_ready = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; l_ready = 1'b0;
    rd(6'h1C, v); chk("R7 push+pop count", v, 32'h0002_0001);
    chk("R7 new head", 32'(l_data), 32'h6666);
    wr(6'h00, 32'hC1);
    rd(6'h1C, v); chk("R11 input clear", v, 0);
    rd(6'h00, v); chk("R11 reset bits read 0", v, 32'h1);
  endtask

  task automatic t_result;
    logic [31:0] v;
    chk("R5 ready", 32'(res_ready), 1);
    push_res(32'h11); push_res(32'h22); push_res(32'h33);
    rd(6'h20, v); chk("R8 out count", v, 3);
    rd(6'h0C, v); chk("R5 pop 1", v, 32'h11);
    rd(6'h0C, v); chk("R5 pop 2", v, 32'h22);
    rd(6'h0C, v); chk("R5 pop 3", v, 32'h33);
    rd(6'h0C, v); chk("R5 empty read", v, 0);
    rd(6'h20, v); chk("R5 count after empty read", v, 0);
  endtask

  task automatic t_levels;
    logic [31:0] v;
    wr(6'h28, 32'h2);
    push_res(32'hA); push_res(32'hB);
    wr(6'h24, 32'h0000_0003);
    wr(6'h08, 32'h0002_0001); wr(6'h08, 32'h0002_0001);
    rd(6'h24, v); chk("R9 in thresholds", v, 32'h3);
    rd(6'h18, v); chk("R9 flags", v, 32'h044);
    wr(6'h00, 32'h21);
    rd(6'h20, v); chk("R11 out clear", v, 0);
    rd(6'h1C, v); chk("R11 inputs untouched", v, 32'h0002_0002);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(6'h10, 32'h2);
    chk("R10 not yet set", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq set", 32'(irq), 1);
    rd(6'h14, v); chk("R10 status", v, 32'h2);
    wr(6'h14, 32'h2);
    rd(6'h14, v); chk("R10 set wins over clear", v, 32'h2);
    wr(6'h10, 32'h0);
    wr(6'h14, 32'h2);
    chk("R10 irq cleared", 32'(irq), 0);
    rd(6'h14, v); chk("R10 status cleared", v, 0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(6'h00, 32'hC1);
    for (int i = 0; i < 256; i++) wr(6'h08, {16'h8000 | 16'(i), 16'(i)});
    rd(6'h18, v); chk("R9 full flags", v, 32'h112);
    pop_lr(1'b0, 1'b1);
    wr(6'h08, 32'hEEEE_FFFF);
    rd(6'h1C, v); chk("R6 counts", v, 32'h0100_0100);
    chk("R6 left head kept", 32'(l_data), 0);
    chk("R6 right head", 32'(r_data), 32'h8001);
  endtask

  task automatic t_dma;
    wr(6'h00, 32'h301);
    chk("R12 in req off when full", 32'(in_dma_req), 0);
    chk("R12 out req off when empty", 32'(out_dma_req), 0);
    wr(6'h00, 32'h3C1);
    @(negedge clk);
    chk("R12 in req", 32'(in_dma_req), 1);
    push_res(32'h1); push_res(32'h2);
    chk("R12 out req", 32'(out_dma_req), 1);
  endtask

  task automatic t_core;
    wr(6'h00, 32'h11);
    chk("R11 restart pulse", 32'(core_restart), 1);
    @(negedge clk);
    chk("R11 restart one cycle", 32'(core_restart), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_split();
    t_swap();
    t_gate();
    t_same_cycle();
    t_result();
    t_levels();
    t_irq();
    t_full();
    t_dma();
    t_core();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule